// File: doc/BRIEF.md
# Capture Sampling Controller

This block is the control side of a 16-channel logic-capture front end. Software reaches it through a plain byte-wide register port: an 8-bit address, an 8-bit write bus with a write strobe, and a read bus that always shows the register at the current address. The block selects one of two base time sources, a slower one and a faster one. Each arrives as a one-cycle tick input. The block divides the selected ticks down to a sample strobe and latches the enabled subset of the 16 channel inputs on every strobe.

A control register holds an arm bit and a run bit. Writing it with a pulse bit set clears the sticky FIFO-overflow flag and restarts the divider phase. The pulse bit itself is never stored. The register reads back an idle indication and the overflow flag next to the stored bits, so a setup sequence and a stop can each be confirmed by reading fixed values. The sample FIFO is outside the block; only its full signal comes in.

Top module: `capture_ctrl`

## Requirements
- R1: Address 0x00 reads the VERSION parameter, which must be 0x10, 0x40 or 0x41 (default 0x41). Writes to it have no effect.
- R2: Address 0x0A stores and reads back the full byte written (reset 0x00). Its bit 0 selects the tick source: 0 selects tick_slow and 1 selects tick_fast. Ticks from the unselected source are ignored.
- R3: Address 0x04 holds D (reset 0x00). While running, the N-th selected tick since the start yields an internal strobe when N is a multiple of D+1, so the divider covers 1 to 256.
- R4: Addresses 0x02 and 0x03 hold channel-mask bits 7:0 and 15:8 (reset 0x0000). One cycle after an internal strobe, sample_stb is high for one cycle and sample_data equals chan_in AND mask, both taken at the strobe cycle.
- R5: Address 0x01 reads {0, arm, ovf, 0, idle, 0, 0, run}, where arm is bit 6, ovf is bit 5, idle is bit 3 (idle = NOT run) and run is bit 0. It reads 0x08 after reset.
- R6: A write to 0x01 stores wdata bit 6 as arm and wdata bit 0 as run. When wdata bit 1 is set, the write clears ovf and the divider phase, and bit 1 is not stored. Writing 0x40, then 0x42, then 0x40 leaves 0x01 reading 0x48.
- R7: Writing 0x41 to 0x01 starts sampling: running goes high and idle goes low in the next cycle. Writing 0x00 stops sampling, after which 0x01 reads 0x08 once bit 5 is masked.
- R8: ovf sets when fifo_full is high in an internal-strobe cycle. It stays set through a stop and clears only on a pulse write.
- R9: Reads of unmapped addresses (anything except 0x00 to 0x04 and 0x0A) return 0x00. Writes to them change no register.
- R10: While stopped, no sample_stb is produced and sample_data holds its last value. A restart begins a fresh divider count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for the current address |
| tick_slow | input | 1 | One-cycle tick of the slower base source |
| tick_fast | input | 1 | One-cycle tick of the faster base source |
| fifo_full | input | 1 | Full indication from the external sample FIFO |
| chan_in | input | 16 | Channel inputs |
| sample_stb | output | 1 | One-cycle sample-valid pulse |
| sample_data | output | 16 | Masked channel sample |
| running | output | 1 | Capture is running |
| idle | output | 1 | Capture is stopped |

## Verification
The divider is driven with ticks on every cycle, with sparse ticks on every third cycle, and with ticks only on the unselected source. These patterns separate counting ticks from counting clocks and show whether the source select is honoured. Divisors 1, 4 and 256 cover both ends of the range. Mixed channel masks with changing inputs show that the mask bytes land in the right halves. A full FIFO raised only around one strobe tells apart a flag that is sticky from one that follows the input, and a flag set on strobes from one set on any cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_VER     = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h01;
  localparam logic [ADDR_W-1:0] A_MASK_LO = 8'h02;
  localparam logic [ADDR_W-1:0] A_DIV     = 8'h04;
  localparam logic [ADDR_W-1:0] A_CLKSEL  = 8'h0A;

  localparam int CB_RUN   = 0;
  localparam int CB_PULSE = 1;
  localparam int CB_IDLE  = 3;
  localparam int CB_OVF   = 5;
  localparam int CB_ARM   = 6;

  // control/status readback byte
  function automatic logic [DATA_W-1:0] ctrl_status(input logic arm, input logic ovf,
                                                    input logic run);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CB_ARM]  = arm;
    v[CB_OVF]  = ovf;
    v[CB_IDLE] = ~run;
    v[CB_RUN]  = run;
    return v;
  endfunction

  function automatic logic version_ok(input logic [DATA_W-1:0] v);
    return (v == 8'h10) || (v == 8'h40) || (v == 8'h41);
  endfunction
endpackage

// File: rtl/cap_regs.sv
module cap_regs
  import cap_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h41,
  parameter int         CH      = 16,
  parameter int         DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_i,
  output logic              run_o,
  output logic              pulse_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [CH-1:0]     mask_o,
  output logic              clksel_o,
  output logic [DATA_W-1:0] rdata
);
  localparam int MB = CH / 8;

  logic              arm_q, run_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] clksel_q;
  logic              wr_ctrl;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign pulse_o = wr_ctrl && wdata[CB_PULSE];

  initial begin
    p_version_ok_r1: assert (version_ok(VERSION));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q    <= 1'b0;
      run_q    <= 1'b0;
      div_q    <= '0;
      clksel_q <= '0;
    end else if (wr_en) begin
      if (wr_ctrl) begin
        arm_q <= wdata[CB_ARM];
        run_q <= wdata[CB_RUN];
      end
      if (addr == A_DIV)    div_q    <= wdata[DIV_W-1:0];
      if (addr == A_CLKSEL) clksel_q <= wdata;
    end
  end

  for (genvar g = 0; g < MB; g++) begin : g_mask
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n) byte_q <= '0;
      else if (wr_en && (addr == A_MASK_LO + ADDR_W'(g))) byte_q <= wdata;
    end
    assign mask_o[g*8 +: 8] = byte_q;
  end

  assign run_o    = run_q;
  assign div_o    = div_q;
  assign clksel_o = clksel_q[0];

  always_comb begin
    rdata = '0;
    if (addr == A_VER)    rdata = VERSION;
    if (addr == A_CTRL)   rdata = ctrl_status(arm_q, ovf_i, run_q);
    if (addr == A_DIV)    rdata = DATA_W'(div_q);
    if (addr == A_CLKSEL) rdata = clksel_q;
    for (int k = 0; k < MB; k++)
      if (addr == A_MASK_LO + ADDR_W'(k)) rdata = mask_o[k*8 +: 8];
  end

  p_ctrl_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (arm_q == $past(wdata[CB_ARM])) && (run_q == $past(wdata[CB_RUN])));
endmodule

// File: rtl/cap_div.sv
module cap_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             sel_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             stb_o
);
  logic [DIV_W-1:0] cnt;
  logic             tick;
  logic             at_end;

  assign tick   = sel_i ? tick_fast : tick_slow;
  assign at_end = (cnt == div_i);
  assign stb_o  = run_i && tick && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || clr_i) cnt <= '0;
    else if (tick) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> (cnt == '0));
  p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt == '0));
endmodule

// File: rtl/cap_gate.sv
module cap_gate #(
  parameter int CH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          clr_i,
  input  logic          fifo_full,
  input  logic [CH-1:0] chan_in,
  input  logic [CH-1:0] mask_i,
  output logic          stb_o,
  output logic [CH-1:0] data_o,
  output logic          ovf_o
);
  logic          stb_q, ovf_q;
  logic [CH-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      data_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      stb_q <= stb_i;
      if (stb_i) data_q <= chan_in & mask_i;
      if (clr_i) ovf_q <= 1'b0;
      else if (stb_i && fifo_full) ovf_q <= 1'b1;
    end
  end

  assign stb_o  = stb_q;
  assign data_o = data_q;
  assign ovf_o  = ovf_q;

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !clr_i |=> ovf_q);
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && fifo_full && !clr_i |=> ovf_q);
  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(data_q));
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import cap_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h41,
  parameter int         CH      = 16,
  parameter int         DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              fifo_full,
  input  logic [CH-1:0]     chan_in,
  output logic              sample_stb,
  output logic [CH-1:0]     sample_data,
  output logic              running,
  output logic              idle
);
  logic             run_w, pulse_w, clksel_w, stb_w, ovf_w;
  logic [DIV_W-1:0] div_w;
  logic [CH-1:0]    mask_w;

  cap_regs #(.VERSION(VERSION), .CH(CH), .DIV_W(DIV_W)) u_regs (
    .clk, .rst_n, .wr_en, .addr, .wdata,
    .ovf_i(ovf_w), .run_o(run_w), .pulse_o(pulse_w), .div_o(div_w),
    .mask_o(mask_w), .clksel_o(clksel_w), .rdata
  );

  cap_div #(.DIV_W(DIV_W)) u_div (
    .clk, .rst_n, .tick_slow, .tick_fast,
    .sel_i(clksel_w), .run_i(run_w), .clr_i(pulse_w), .div_i(div_w), .stb_o(stb_w)
  );

  cap_gate #(.CH(CH)) u_gate (
    .clk, .rst_n, .stb_i(stb_w), .clr_i(pulse_w), .fifo_full, .chan_in,
    .mask_i(mask_w), .stb_o(sample_stb), .data_o(sample_data), .ovf_o(ovf_w)
  );

  assign running = run_w;
  assign idle    = ~run_w;

  p_stb_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(running));
endmodule

// File: tb/capture_ctrl_tb.sv
`timescale 1ns/100ps
module capture_ctrl_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0, wdata = 0;
  logic [7:0]  rdata;
  logic        tick_slow = 0, tick_fast = 0, fifo_full = 0;
  logic [15:0] chan_in = 0;
  logic        sample_stb, running, idle;
  logic [15:0] sample_data;

  int compared = 0, mismatched = 0;
  int tmode = 0, cyc = 0;
  bit checking = 0, done = 0;

  capture_ctrl u_dut (.*);

  always #2.5 clk = ~clk;

  // reference model state
  bit m_run, m_arm, m_ovf, m_stb;
  int m_div, m_cnt;
  logic [15:0] m_mask, m_data;
  logic [7:0]  m_sel;
  int strobes = 0;

  always @(posedge clk) begin
    bit tk, fire, pulse;
    if (!rst_n) begin
      m_run = 0; m_arm = 0; m_ovf = 0; m_stb = 0; m_div = 0; m_cnt = 0;
      m_mask = 0; m_data = 0; m_sel = 0;
    end else begin
      tk    = m_sel[0] ? tick_fast : tick_slow;
      fire  = m_run && tk && (m_cnt == m_div);
      pulse = wr_en && addr == 8'h01 && wdata[1];
      m_stb = fire;
      if (fire) begin m_data = chan_in & m_mask; strobes++; end
      if (pulse) m_ovf = 0; else if (fire && fifo_full) m_ovf = 1;
      if (!m_run || pulse) m_cnt = 0; else if (tk) m_cnt = fire ? 0 : m_cnt + 1;
      if (wr_en) case (addr)
        8'h01: begin m_run = wdata[0]; m_arm = wdata[6]; end
        8'h02: m_mask[7:0]  = wdata;
        8'h03: m_mask[15:8] = wdata;
        8'h04: m_div = wdata;
        8'h0A: m_sel = wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return 8'h41;
      8'h01: return {1'b0, m_arm, m_ovf, 1'b0, ~m_run, 2'b00, m_run};
      8'h02: return m_mask[7:0];
      8'h03: return m_mask[15:8];
      8'h04: return m_div[7:0];
      8'h0A: return m_sel;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the sampling outputs (R3, R4, R7, R10)
  always @(negedge clk) begin
    if (checking) begin
      chk("R3 R10 sample_stb", sample_stb, m_stb);
      chk("R4 sample_data", sample_data, m_data);
      chk("R7 running", running, m_run);
      chk("R7 idle", idle, !m_run);
    end
  end

  // tick and channel stimulus
  always @(negedge clk) begin
    cyc++;
    chan_in <= 16'($urandom);
    case (tmode)
      1: begin tick_slow <= 1; tick_fast <= 0; end
      2: begin tick_slow <= (cyc % 3 == 0); tick_fast <= 0; end
      3: begin tick_slow <= 0; tick_fast <= 1; end
      4: begin tick_slow <= 1; tick_fast <= (cyc % 2 == 0); end
      default: begin tick_slow <= 0; tick_fast <= 0; end
    endcase
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk); wr_en = 0; addr = a;
    #1 chk(req, rdata, model_read(a));
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk); wr_en = 0; addr = a;
    #1 chk(req, rdata, e);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    checking = 1;
    // reset state
    rd_exp(8'h01, 8'h08, "R5 reset status");
    rd_exp(8'h00, 8'h41, "R1 version");
    rd_exp(8'h04, 8'h00, "R3 reset divider");
    rd_exp(8'h0A, 8'h00, "R2 reset clock select");
    wr(8'h00, 8'h99);
    rd_exp(8'h00, 8'h41, "R1 version write ignored");

    // setup sequence
    wr(8'h01, 8'h40); wr(8'h01, 8'h42); wr(8'h01, 8'h40);
    rd_exp(8'h01, 8'h48, "R6 setup readback");

    // mask and divider 4, slow every cycle
    wr(8'h02, 8'hC3); wr(8'h03, 8'hA5); wr(8'h04, 8'h03); wr(8'h0A, 8'h00);
    rd_exp(8'h02, 8'hC3, "R4 mask low");
    rd_exp(8'h03, 8'hA5, "R4 mask high");
    tmode = 1;
    s0 = strobes;
    wr(8'h01, 8'h41);
    rd_exp(8'h01, 8'h41, "R7 running status");
    repeat (40) @(negedge clk);
    chk("R3 strobes seen", strobes > s0, 1);

    // sparse ticks, then only the unselected source
    tmode = 2; repeat (60) @(negedge clk);
    tmode = 3; s0 = strobes; repeat (30) @(negedge clk);
    chk("R2 unselected ticks ignored", strobes, s0);

    // stop, switch to fast source
    wr(8'h01, 8'h40);
    s0 = strobes; repeat (20) @(negedge clk);
    chk("R10 no strobe when stopped", strobes, s0);
    wr(8'h0A, 8'h81);
    rd_exp(8'h0A, 8'h81, "R2 full byte readback");
    tmode = 4;
    wr(8'h01, 8'h41);
    repeat (50) @(negedge clk);
    wr(8'h01, 8'h40);

    // divider extremes
    wr(8'h0A, 8'h00); wr(8'h04, 8'h00); tmode = 1;
    wr(8'h01, 8'h41); repeat (20) @(negedge clk); wr(8'h01, 8'h40);
    wr(8'h04, 8'hFF);
    s0 = strobes;
    wr(8'h01, 8'h41); repeat (600) @(negedge clk); wr(8'h01, 8'h40);
    chk("R3 divide by 256 strobe count", strobes - s0, 2);

    // overflow behaviour
    wr(8'h04, 8'h01);
    wr(8'h01, 8'h41);
    repeat (6) @(negedge clk);
    fifo_full = 1; repeat (3) @(negedge clk); fifo_full = 0;
    repeat (4) @(negedge clk);
    rd_exp(8'h01, 8'h61, "R8 overflow set");
    wr(8'h01, 8'h00);
    rd_exp(8'h01, 8'h28, "R8 overflow survives stop");
    @(negedge clk); addr = 8'h01; #1 chk("R7 stop status masked", rdata & 8'hDF, 8'h08);
    fifo_full = 1; repeat (5) @(negedge clk); fifo_full = 0;
    wr(8'h01, 8'h42);
    rd_exp(8'h01, 8'h48, "R6 pulse clears overflow");
    wr(8'h01, 8'h40);
    rd(8'h01, "R5 status vs model");

    // unmapped addresses
    wr(8'h05, 8'h77); wr(8'hFF, 8'h55); wr(8'h0B, 8'h12);
    rd_exp(8'h05, 8'h00, "R9 unmapped read 0x05");
    rd_exp(8'hFF, 8'h00, "R9 unmapped read 0xFF");
    rd_exp(8'h04, 8'h01, "R9 divider unchanged");
    rd_exp(8'h0A, 8'h00, "R9 clock select unchanged");
    rd_exp(8'h02, 8'hC3, "R9 mask unchanged");
    rd_exp(8'h01, 8'h48, "R9 status unchanged");

    tmode = 0;
    repeat (4) @(negedge clk);
    checking = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule